// File: doc/BRIEF.md
# Two-Wire Slave Interface for a DAC Peripheral

This block is the serial front end of a small digital-to-analog converter. It watches the two bus lines, SCL and SDA, by sampling them with the system clock. It finds START, repeated START and STOP conditions and decodes a seven-bit device address. Six of the address bits are fixed at build time and the lowest bit follows a strap pin. The block answers on SDA only through a pull-low enable, which drives an open-drain pad.

In a write, the block acknowledges each data byte. It hands every byte to the command decoder as a one-cycle pulse that carries a byte index, 0 or 1, within the two-byte word. A separate pulse marks the SCL falling edge that ends the acknowledge slot, and the decoder commits its registers on that pulse. In a read, the block shifts out two bytes taken from the register block, MSB first, and after each byte it samples the master's acknowledge. The block stops listening in three cases: on the first address bit that does not match, after a STOP, and after a NACK from the master. From then on it ignores SCL until the next START.

Top module: `i2c_dac_slave`

## Requirements
- R1: The device address is {ADDR_HI[5:0], addr_sel}. When a START is followed by this address, sent MSB first, and an eighth bit of 0 (write), sda_pull is 1 for the whole ninth SCL clock.
- R2: Address bits are compared as they arrive. After the first mismatching bit, sda_pull stays 0 and byte_done stays 0, whatever SCL and SDA do, until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP ends a transfer at any bit, and all later bus activity is ignored until a START.
- R4: A STOP that comes in the same SCL high phase as the START before it is ignored, and the transfer goes on.
- R5: The address 0000000 is never acknowledged, and bytes that follow it are ignored until a START.
- R6: In a write, each data byte is acknowledged by sda_pull being 1 for the ninth clock. On the eighth SCL rising edge, byte_done pulses for one cycle with the byte on wr_byte. byte_idx goes 0, 1, 0, 1 within a transfer and restarts at 0 after every START.
- R7: ack_fall pulses for one cycle on the SCL falling edge that ends the acknowledge of each write data byte. sda_pull is 0 in that cycle and afterwards.
- R8: A repeated START, sent without a STOP, returns the block to address phase. Either write or read may follow it.
- R9: When the eighth address bit is 1 (read), the block sends rd_byte0 MSB first after the address acknowledge. A 0 data bit shows as sda_pull = 1. When the master acknowledges (SDA low on the ninth clock), rd_byte1 follows, then rd_byte0 again. On a NACK, SDA is released and the bus is ignored until a START.
- R10: sda_pull changes only after an SCL falling edge has been detected, never while SCL is high. After reset sda_pull, byte_done and ack_fall are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strap that sets address bit 0 |
| rd_byte0 | input | 8 | First byte sent in a read |
| rd_byte1 | input | 8 | Second byte sent in a read |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_byte | output | 8 | Last received write data byte |
| byte_done | output | 1 | One-cycle pulse: wr_byte is valid |
| byte_idx | output | 1 | Index of wr_byte within the two-byte word |
| ack_fall | output | 1 | One-cycle pulse on the SCL fall that ends a write acknowledge |

## Verification
A bus edge enters a two-flop synchronizer and is seen as an edge one cycle later, so sda_pull, byte_done and ack_fall react on the third rising clock after the pin changes. The bench drives each bus level for eight clocks. After every line change it skips five cycles, then compares sda_pull with the model on every cycle until the next change. byte_done is not tied to a fixed cycle: each pulse is matched against a queue of expected index and byte pairs, so both an early pulse and an extra pulse show up. The ack_fall pulses are counted against the number of acknowledged write data bytes.

// File: rtl/i2c_dac_slave.sv
`timescale 1ns/1ps
module i2c_dac_slave #(
  parameter logic [5:0] ADDR_HI = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_sel,
  input  logic [7:0] rd_byte0,
  input  logic [7:0] rd_byte1,
  output logic       sda_pull,
  output logic [7:0] wr_byte,
  output logic       byte_done,
  output logic       byte_idx,
  output logic       ack_fall
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [6:0] rx, tx;
  logic       rnw, widx, ridx, start_hi;
  logic [6:0] my_addr;
  logic       sda_s, scl_rise, scl_fall, scl_hi, start_c, stop_c, listening;

  assign my_addr   = {ADDR_HI, addr_sel};
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign scl_hi    = scl_q[1] & scl_q[2];
  assign start_c   = scl_hi & sda_q[2] & ~sda_q[1];
  assign stop_c    = scl_hi & ~sda_q[2] & sda_q[1];
  assign listening = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      rnw       <= 1'b0;
      widx      <= 1'b0;
      ridx      <= 1'b0;
      start_hi  <= 1'b0;
      sda_pull  <= 1'b0;
      wr_byte   <= '0;
      byte_done <= 1'b0;
      byte_idx  <= 1'b0;
      ack_fall  <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      ack_fall  <= 1'b0;
      if (scl_fall) start_hi <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
        widx     <= 1'b0;
        start_hi <= 1'b1;
      end else if (stop_c && !start_hi) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) rx <= {rx[5:0], sda_s};
          case (st)
            ST_ADDR: begin
              if (cnt < 4'd7 && sda_s != my_addr[3'd6 - cnt[2:0]]) st <= ST_IDLE;
              else if (cnt == 4'd7) begin
                rnw <= sda_s;
                if (my_addr == 7'd0) st <= ST_IDLE;
              end
            end
            ST_WR: if (cnt == 4'd7) begin
              byte_done <= 1'b1;
              wr_byte   <= {rx, sda_s};
              byte_idx  <= widx;
            end
            ST_RD: if (cnt == 4'd8 && sda_s) st <= ST_IDLE;
            default: ;
          endcase
        end
        if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_pull <= (st != ST_RD);
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (st)
              ST_ADDR: if (rnw) begin
                st       <= ST_RD;
                tx       <= rd_byte0[6:0];
                sda_pull <= ~rd_byte0[7];
                ridx     <= 1'b1;
              end else begin
                st       <= ST_WR;
                sda_pull <= 1'b0;
              end
              ST_WR: begin
                sda_pull <= 1'b0;
                ack_fall <= 1'b1;
                widx     <= ~widx;
              end
              ST_RD: begin
                tx       <= ridx ? rd_byte1[6:0] : rd_byte0[6:0];
                sda_pull <= ridx ? ~rd_byte1[7] : ~rd_byte0[7];
                ridx     <= ~ridx;
              end
              default: ;
            endcase
          end else if (st == ST_RD && cnt != 4'd0) begin
            tx       <= {tx[5:0], 1'b0};
            sda_pull <= ~tx[6];
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_dac_slave_chk.sv
`timescale 1ns/1ps
module i2c_dac_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull,
  input logic byte_done,
  input logic ack_fall,
  input logic scl_fall,
  input logic listening
);

  a_r10_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !listening |-> !sda_pull);

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  a_r7_ack_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |=> !ack_fall);

  a_r7_ack_fall_released: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fall |-> !sda_pull);

  a_r6_done_apart_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && ack_fall));

endmodule

bind i2c_dac_slave i2c_dac_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .byte_done(byte_done),
  .ack_fall(ack_fall), .scl_fall(scl_fall), .listening(listening)
);

// File: tb/i2c_dac_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_dac_slave_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
  logic [7:0] rd0 = 8'hA5, rd1 = 8'h3C;
  logic sda_pull, byte_done, byte_idx, ack_fall;
  logic [7:0] wr_byte;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, errors = 0, blank = 0, ack_exp = 0, ack_seen = 0;
  logic exp_pull = 1'b0, prev_pull = 1'b0, mon_en = 1'b0, done = 1'b0;
  logic [8:0] e;
  string req = "R10";
  logic [8:0] exp_q[$];

  i2c_dac_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .addr_sel(addr_sel),
    .rd_byte0(rd0), .rd_byte1(rd1), .sda_pull(sda_pull), .wr_byte(wr_byte),
    .byte_done(byte_done), .byte_idx(byte_idx), .ack_fall(ack_fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic fail(input string r, input string what, input int act, input int expv);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", r, what, act, expv);
  endtask

  always begin
    @(posedge clk); #1;
    if (mon_en) begin
      if (blank > 0) blank--;
      else begin
        checks++;
        if (sda_pull !== exp_pull) fail(req, "sda_pull", int'(sda_pull), int'(exp_pull));
      end
      if (sda_pull !== prev_pull) begin
        checks++;
        if (scl_m !== 1'b0) fail("R10", "sda_pull moved with SCL high", int'(scl_m), 0);
      end
      prev_pull = sda_pull;
      if (byte_done) begin
        checks++;
        if (exp_q.size() == 0) fail("R6", "unexpected byte_done", int'({byte_idx, wr_byte}), 0);
        else begin
          e = exp_q.pop_front();
          if ({byte_idx, wr_byte} !== e) fail("R6", "idx/byte", int'({byte_idx, wr_byte}), int'(e));
        end
      end
      if (ack_fall) ack_seen++;
    end
  end

  task automatic drv(input logic c, input logic d, input logic ex);
    @(negedge clk);
    scl_m = c; sda_m = d; exp_pull = ex; blank = 5;
    repeat (7) @(negedge clk);
  endtask

  task automatic bit_slot(input logic m, input logic ecur, input logic enext);
    drv(1'b0, m, ecur);
    drv(1'b1, m, ecur);
    drv(1'b0, m, enext);
  endtask

  task automatic bus_start();
    drv(1'b0, 1'b1, 1'b0);
    drv(1'b1, 1'b1, 1'b0);
    drv(1'b1, 1'b0, 1'b0);
    drv(1'b0, 1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    drv(1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0);
    drv(1'b1, 1'b1, 1'b0);
  endtask

  task automatic wbyte(input logic [7:0] b, input logic ack, input logic after);
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, (i == 0) ? ack : 1'b0);
    bit_slot(1'b1, ack, after);
  endtask

  task automatic wdata(input logic idx, input logic [7:0] b);
    exp_q.push_back({idx, b});
    ack_exp++;
    wbyte(b, 1'b1, 1'b0);
  endtask

  task automatic rbyte(input logic [7:0] d, input logic mack, input logic after);
    for (int i = 7; i >= 0; i--) begin
      logic nxt;
      nxt = 1'b0;
      if (i > 0) nxt = ~d[i-1];
      bit_slot(1'b1, ~d[i], nxt);
    end
    bit_slot(mack ? 1'b0 : 1'b1, 1'b0, after);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++; if (sda_pull !== 1'b0) fail("R10", "reset sda_pull", int'(sda_pull), 0);
    checks++; if (byte_done !== 1'b0) fail("R10", "reset byte_done", int'(byte_done), 0);
    checks++; if (ack_fall !== 1'b0) fail("R10", "reset ack_fall", int'(ack_fall), 0);
    mon_en = 1'b1;

    req = "R1"; bus_start(); wbyte(8'h22, 1'b1, 1'b0);
    req = "R6"; wdata(1'b0, 8'hC5); wdata(1'b1, 8'h3A); bus_stop();

    req = "R6"; bus_start(); wbyte(8'h22, 1'b1, 1'b0);
    wdata(1'b0, 8'h01); wdata(1'b1, 8'h80); wdata(1'b0, 8'hFF); wdata(1'b1, 8'h00); bus_stop();

    req = "R2"; bus_start(); wbyte(8'h20, 1'b0, 1'b0);
    wbyte(8'h22, 1'b0, 1'b0); wbyte(8'h5A, 1'b0, 1'b0); bus_stop();
    bus_start(); wbyte(8'hA2, 1'b0, 1'b0); wbyte(8'h22, 1'b0, 1'b0); bus_stop();

    req = "R1"; addr_sel = 1'b0;
    bus_start(); wbyte(8'h20, 1'b1, 1'b0); wdata(1'b0, 8'h77); bus_stop();
    addr_sel = 1'b1;

    req = "R3"; bus_start(); wbyte(8'h22, 1'b1, 1'b0); wdata(1'b0, 8'h12); bus_stop();
    wbyte(8'h22, 1'b0, 1'b0); wbyte(8'h34, 1'b0, 1'b0);
    bus_start(); wbyte(8'h22, 1'b1, 1'b0);
    bit_slot(1'b1, 1'b0, 1'b0); bit_slot(1'b0, 1'b0, 1'b0); bit_slot(1'b1, 1'b0, 1'b0);
    bus_stop(); wbyte(8'h22, 1'b0, 1'b0); wbyte(8'h66, 1'b0, 1'b0);

    req = "R8"; bus_start(); wbyte(8'h22, 1'b1, 1'b0); wdata(1'b0, 8'h11);
    bus_start(); wbyte(8'h22, 1'b1, 1'b0); wdata(1'b0, 8'h44); bus_stop();

    req = "R4";
    drv(1'b0, 1'b1, 1'b0); drv(1'b1, 1'b1, 1'b0); drv(1'b1, 1'b0, 1'b0);
    drv(1'b1, 1'b1, 1'b0); drv(1'b0, 1'b1, 1'b0);
    wbyte(8'h22, 1'b1, 1'b0); wdata(1'b0, 8'h9C); bus_stop();

    req = "R5"; bus_start(); wbyte(8'h00, 1'b0, 1'b0); wbyte(8'h22, 1'b0, 1'b0); bus_stop();

    req = "R9"; bus_start(); wbyte(8'h23, 1'b1, ~rd0[7]);
    rbyte(rd0, 1'b1, ~rd1[7]); rbyte(rd1, 1'b1, ~rd0[7]); rbyte(rd0, 1'b0, 1'b0);
    wbyte(8'h00, 1'b0, 1'b0); bus_stop();

    req = "R8"; rd0 = 8'h5E; rd1 = 8'h81;
    bus_start(); wbyte(8'h22, 1'b1, 1'b0);
    bus_start(); wbyte(8'h23, 1'b1, ~rd0[7]);
    rbyte(rd0, 1'b1, ~rd1[7]); rbyte(rd1, 1'b0, 1'b0); bus_stop();

    repeat (10) @(negedge clk);
    checks++; if (exp_q.size() != 0) fail("R6", "missing byte_done pulses", exp_q.size(), 0);
    checks++; if (ack_seen != ack_exp) fail("R7", "ack_fall count", ack_seen, ack_exp);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail("R10", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule